// File: doc/BRIEF.md
# Programmable Reference Divider with Monitor Output

This block takes a reference clock and divides it down to the comparison rate that a phase comparator needs. A 4-bit code picks one of sixteen ratios. The ratio set is irregular: the powers of two from 2 to 256, the value 24, and five times a power of two from 5 to 320. Because of that set, a single loadable down-counter produces every ratio. A binary divider chain with taps could not.

The comparison rate appears in two forms. The first is a pulse that lasts one reference cycle and repeats once per period. The second is a square form with 50% duty cycle for the even ratios. A change of ratio code is applied only at the next terminal count, so no shortened period can occur.

A monitor output, with its own output-enable, is meant to drive a pad. It can be switched off, carry the raw reference clock, or carry the divided comparison clock. The two control bits that choose among these are registered and both reset to 1. As a result, the comparison clock is on the monitor after reset.

Top module: `refDivTop`

## Requirements
- R1: Ratio codes 0 to 7 divide by 2, 4, 8, 16, 32, 64, 128 and 256 respectively (`cmpPulse` period in reference cycles).
- R2: Ratio codes 8 to 15 divide by 24, 5, 10, 20, 40, 80, 160 and 320 respectively.
- R3: `cmpPulse` is high for exactly one reference cycle per division period.
- R4: For an even ratio N, `cmpClk` is high for exactly N/2 cycles of every N consecutive cycles.
- R5: A new ratio code takes effect only at the next terminal count. The period that is running when the code changes completes at the old length.
- R6: While the registered enable is 0, `monOe` is 0 and `monOut` is held at 0.
- R7: While enable is 1 and select is 0, `monOut` follows `refClk` in both clock phases.
- R8: While enable and select are both 1, `monOut` carries the comparison clock. For an even ratio this is `cmpClk`. For an odd ratio it is `cmpPulse`, so the output is high once per period.
- R9: During reset, `cmpPulse` is 0, the enable and select registers are 1 (so `monOe` is 1), and the monitor selects the comparison clock.
- R10: `monEnable` and `monSelect` are captured on the rising edge of `refClk`. A change shows at `monOe`/`monOut` after the first rising edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock, also the monitor source when select is 0 |
| rstN | input | 1 | Active-low synchronous reset |
| ratioCode | input | 4 | Division ratio code |
| monEnable | input | 1 | Monitor enable (1 = drive the pad) |
| monSelect | input | 1 | Monitor source: 0 = reference, 1 = comparison clock |
| cmpPulse | output | 1 | One-cycle pulse per comparison period |
| cmpClk | output | 1 | Square comparison clock (50% duty for even ratios) |
| monOut | output | 1 | Monitor data toward the pad buffer |
| monOe | output | 1 | Monitor output enable (0 = high impedance) |

## Verification
All sixteen ratio codes are walked in turn. For each code the bench measures the pulse-to-pulse spacing, so a wrong entry in either half of the ratio set is detected. In the same window it counts the high cycles of `cmpClk` and of the monitor. This separates a correct half-period from an off-by-one, and confirms that ratio 5 uses the pulse form.

A code change made partway through the 256 period shows whether the counter waits for its terminal count. A jump to ratio 2 at that point would otherwise produce an early pulse. The monitor is also sampled in both clock phases under each enable/select setting, and once during reset. This separates the reference path from the divided path and from the disabled path.

// File: rtl/refDivPkg.sv
package refDivPkg;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 9;

  typedef struct packed {
    logic tcStrobe;
    logic lowHalf;
    logic oddRatio;
  } divStrobe_t;

  function automatic logic [CNT_W-1:0] ratioOf(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] one2;
    logic [CNT_W-1:0] five;
    one2 = CNT_W'(2);
    five = CNT_W'(5);
    if (!code[CODE_W-1])
      return one2 << code[CODE_W-2:0];
    else if (code[CODE_W-2:0] == '0)
      return CNT_W'(24);
    else
      return five << (code[CODE_W-2:0] - 3'd1);
  endfunction
endpackage

// File: rtl/refDivCtrl.sv
module refDivCtrl
  import refDivPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CODE_W-1:0]    ratioCode,
  output divStrobe_t           strobes
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] activeRatio;
  logic [CNT_W-1:0] nextRatio;
  logic [CNT_W-1:0] halfRatio;
  logic             tc;

  assign nextRatio = ratioOf(ratioCode);
  assign halfRatio = activeRatio >> 1;
  assign tc        = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count       <= '0;
      activeRatio <= ratioOf('0);
    end else if (tc) begin
      count       <= nextRatio - CNT_W'(1);
      activeRatio <= nextRatio;
    end else begin
      count <= count - CNT_W'(1);
    end
  end

  always_comb begin
    strobes.tcStrobe = tc;
    strobes.lowHalf  = (count < halfRatio);
    strobes.oddRatio = activeRatio[0];
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    count < activeRatio);

  // R5
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tc |=> $stable(activeRatio));
endmodule

// File: rtl/refDivPath.sv
module refDivPath
  import refDivPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  divStrobe_t strobes,
  input  logic       monEn,
  input  logic       monSel,
  output logic       cmpPulse,
  output logic       cmpClk,
  output logic       monOut
);
  logic oddReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpPulse <= 1'b0;
      cmpClk   <= 1'b0;
      oddReg   <= 1'b0;
    end else begin
      cmpPulse <= strobes.tcStrobe;
      cmpClk   <= strobes.lowHalf;
      oddReg   <= strobes.oddRatio;
    end
  end

  always_comb begin
    if (!monEn)
      monOut = 1'b0;
    else if (monSel)
      monOut = oddReg ? cmpPulse : cmpClk;
    else
      monOut = clk;
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpPulse |=> !cmpPulse);
endmodule

// File: rtl/refDivTop.sv
module refDivTop
  import refDivPkg::*;
(
  input  logic              refClk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ratioCode,
  input  logic              monEnable,
  input  logic              monSelect,
  output logic              cmpPulse,
  output logic              cmpClk,
  output logic              monOut,
  output logic              monOe
);
  divStrobe_t strobes;
  logic       monEnReg;
  logic       monSelReg;

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      monEnReg  <= 1'b1;
      monSelReg <= 1'b1;
    end else begin
      monEnReg  <= monEnable;
      monSelReg <= monSelect;
    end
  end

  assign monOe = monEnReg;

  refDivCtrl uCtrl (
    .clk       (refClk),
    .rstN      (rstN),
    .ratioCode (ratioCode),
    .strobes   (strobes)
  );

  refDivPath uPath (
    .clk      (refClk),
    .rstN     (rstN),
    .strobes  (strobes),
    .monEn    (monEnReg),
    .monSel   (monSelReg),
    .cmpPulse (cmpPulse),
    .cmpClk   (cmpClk),
    .monOut   (monOut)
  );

  // R10
  en_follow_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $past(rstN) |-> (monOe == $past(monEnable)));

  // R6
  always_comb begin
    if (rstN && !monOe) begin
      mon_quiet_chk: assert (monOut == 1'b0);
    end
  end
endmodule

// File: tb/tb_refDivTop.sv
module tb_refDivTop;
  logic       refClk = 1'b0;
  logic       rstN;
  logic [3:0] ratioCode;
  logic       monEnable;
  logic       monSelect;
  logic       cmpPulse;
  logic       cmpClk;
  logic       monOut;
  logic       monOe;

  int total = 0;
  int bad   = 0;

  localparam int EXP_RATIO [16] = '{2, 4, 8, 16, 32, 64, 128, 256,
                                    24, 5, 10, 20, 40, 80, 160, 320};

  always #5 refClk = ~refClk;

  refDivTop dut (
    .refClk(refClk), .rstN(rstN), .ratioCode(ratioCode),
    .monEnable(monEnable), .monSelect(monSelect),
    .cmpPulse(cmpPulse), .cmpClk(cmpClk), .monOut(monOut), .monOe(monOe)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitPulse(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge refClk);
      if (cmpPulse) begin ok = 1'b1; break; end
    end
  endtask

  task automatic measure(output int per, output int hi, output int monHi);
    bit ok;
    waitPulse(ok);
    per = 0; hi = 0; monHi = 0;
    if (!ok) begin per = -1; return; end
    for (int i = 0; i < 1000; i++) begin
      @(negedge refClk);
      per++;
      if (cmpClk) hi++;
      if (monOut) monHi++;
      if (cmpPulse) return;
    end
    per = -1;
  endtask

  initial begin
    #3000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, hi, monHi, pulses;
    bit ok;
    rstN = 1'b0; ratioCode = 4'd0; monEnable = 1'b0; monSelect = 1'b0;
    repeat (3) @(negedge refClk);
    // R9 reset state
    check("R9 monOe in reset", int'(monOe), 1);
    check("R9 cmpPulse in reset", int'(cmpPulse), 0);
    check("R9 monOut selects comparison in reset", int'(monOut), 0);
    monEnable = 1'b1; monSelect = 1'b1;
    rstN = 1'b1;

    // R1 R2 R3 R4 R8 walk of all codes
    for (int c = 0; c < 16; c++) begin
      ratioCode = 4'(c);
      waitPulse(ok);
      measure(per, hi, monHi);
      check($sformatf("%s code %0d period", c < 8 ? "R1" : "R2", c), per, EXP_RATIO[c]);
      if (EXP_RATIO[c] % 2 == 0) begin
        check($sformatf("R4 code %0d cmpClk high", c), hi, EXP_RATIO[c] / 2);
        check($sformatf("R8 code %0d monitor high", c), monHi, EXP_RATIO[c] / 2);
      end else begin
        check($sformatf("R8 code %0d odd monitor pulse", c), monHi, 1);
      end
    end

    // R3 pulse width over a ratio-4 stretch
    ratioCode = 4'd1;
    waitPulse(ok); waitPulse(ok);
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge refClk);
      if (cmpPulse) begin
        pulses++;
        @(negedge refClk);
        check("R3 pulse lasts one cycle", int'(cmpPulse), 0);
        i++;
      end
    end
    check("R3 pulse count in 40 cycles", pulses, 10);

    // R5 mid-period change from 256 to 2
    ratioCode = 4'd7;
    waitPulse(ok); waitPulse(ok);
    repeat (10) @(negedge refClk);
    ratioCode = 4'd0;
    per = 10;
    for (int i = 0; i < 400; i++) begin
      @(negedge refClk);
      per++;
      if (cmpPulse) break;
    end
    check("R5 running period keeps old length", per, 256);
    measure(per, hi, monHi);
    check("R5 new ratio after terminal count", per, 2);

    // R7 reference on monitor
    monSelect = 1'b0;
    @(negedge refClk);
    @(posedge refClk); #2;
    check("R7 monOut high phase", int'(monOut), 1);
    @(negedge refClk); #2;
    check("R7 monOut low phase", int'(monOut), 0);
    check("R7 monOe", int'(monOe), 1);

    // R10 capture timing, then R6 disabled
    @(negedge refClk);
    monEnable = 1'b0;
    #2;
    check("R10 monOe before edge", int'(monOe), 1);
    @(posedge refClk); #2;
    check("R10 monOe after edge", int'(monOe), 0);
    check("R6 monOut high phase disabled", int'(monOut), 0);
    @(negedge refClk); #2;
    check("R6 monOut low phase disabled", int'(monOut), 0);
    monSelect = 1'b1;
    repeat (6) begin
      @(posedge refClk); #2;
      check("R6 monOut quiet with select 1", int'(monOut), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule